// File: doc/BRIEF.md
# Configurable Bidirectional I/O Cell Bank

This block is a bank of programmable pad cells. Each cell sits between one internal signal headed for a pad (the drive data) and one external pad, which is modelled as three signals: the level seen at the pad, the value driven onto it and its driver enable. A three-bit role code per cell makes the cell a plain input, an input captured by a register, an input captured by a latch, an output, or a bidirectional pin with three-state control. The value the cell hands back to the internal logic is called the receive data.

Input capture runs from one of several I/O clock lines, chosen per cell. These lines are sampled on the system clock `clk`. A small state machine per cell follows the level of the chosen line. It has two states: `CK_LOW` (the line was last seen low) and `CK_HIGH` (the line was last seen high). The transition `T_RISE` goes from `CK_LOW` to `CK_HIGH` when the line is seen high, and it fires the capture in registered mode. The transition `T_FALL` goes from `CK_HIGH` to `CK_LOW` when the line is seen low. In latched mode the storage follows the pad on every `clk` edge while the chosen line is high.

A per-cell bit picks the driver enable: either the shared global enable or the cell's own product-term enable. An active-low global reset clears all capture storage at once, without waiting for a clock.

Top module: `pio_bank`

## Requirements
- R1: Role code 3'b000 (plain input) makes `rcv_data` follow `pad_in` with no clock. The driver stays off, so `pad_oe` is 0 and `pad_out` is 0.
- R2: Role code 3'b001 (registered input) has two parts. The storage takes `pad_in` at the `clk` edge where the chosen I/O clock line is seen high after having been seen low (`T_RISE`). The line also counts as previously low just after reset. At every other edge the storage holds its value. `rcv_data` shows the stored value.
- R3: Role code 3'b010 (latched input) has two parts. The storage takes `pad_in` at every `clk` edge while the chosen I/O clock line is high, and holds while the line is low. `rcv_data` shows the stored value.
- R4: Role code 3'b011 (output) has two parts. `pad_oe` equals the selected enable, and `rcv_data` is forced to 0.
- R5: Role code 3'b100 (bidirectional) has two parts. `pad_oe` equals the selected enable, and `rcv_data` follows `pad_in` combinationally.
- R6: Role codes 3'b101, 3'b110 and 3'b111 leave the pad high-impedance, so `pad_oe` is 0 and `pad_out` is 0. In these roles `rcv_data` is 0.
- R7: The enable source is picked by `cfg_oe_sel`. When it is 1 the selected enable is `glb_oe`; when it is 0 the selected enable is the cell's `pt_oe` bit.
- R8: `pad_out` equals `drv_data` while `pad_oe` is 1, and is 0 otherwise.
- R9: `cfg_clk_sel` chooses which bit of `io_clk` drives capture: value 0 picks bit 0 and value 1 picks bit 1. The line that is not chosen has no effect on the stored value.
- R10: While `rst_n` is 0, all capture storage is 0 and every state machine is in `CK_LOW`. The clear takes effect as soon as `rst_n` falls, without waiting for a `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which the I/O clock lines are sampled |
| rst_n | input | 1 | Global active-low asynchronous reset |
| io_clk | input | NUM_IOCLK | I/O clock lines shared by all cells |
| glb_oe | input | 1 | Global output enable, active high |
| cfg_mode | input | NCELL*3 | Role code per cell; cell i uses bits [3i+2:3i] |
| cfg_clk_sel | input | NCELL*SEL_W | I/O clock line index per cell |
| cfg_oe_sel | input | NCELL | Per cell: 1 = global enable, 0 = product-term enable |
| pt_oe | input | NCELL | Per-cell product-term output enable |
| drv_data | input | NCELL | Internal data to be driven onto each pad |
| rcv_data | output | NCELL | Pad data returned to internal routing |
| pad_in | input | NCELL | Level seen at each pad |
| pad_out | output | NCELL | Value driven onto each pad |
| pad_oe | output | NCELL | Driver enable per pad |

## Verification
The assertions check several things on every cycle. Registered-mode storage holds except on `T_RISE`, and it takes the sampled pad level when `T_RISE` fires. Latched-mode storage follows the pad while the chosen line is high and holds while it is low. The driver enable is never on outside the output and bidirectional roles, and `pad_out` is quiet whenever the driver is off.

Some behaviour is shown only by the bench's scenarios. These include the full sweep of role codes against enable sources and data patterns, and the clear that reset applies between clock edges. They also include the check that toggling the I/O clock line which is not chosen leaves the stored value untouched. Finally, the scenarios show a rising edge being missed when the role changes to registered input while the chosen line is already high.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int MODE_W = 3;

    // Role of one pad cell
    typedef enum logic [MODE_W-1:0] {
        PM_COMB_IN = 3'd0,
        PM_REG_IN  = 3'd1,
        PM_LAT_IN  = 3'd2,
        PM_OUT     = 3'd3,
        PM_BIDIR   = 3'd4
    } pin_mode_e;

    // Last seen level of the selected I/O clock line
    typedef enum logic {
        CK_LOW  = 1'b0,
        CK_HIGH = 1'b1
    } ck_state_e;

endpackage

// File: rtl/pio_capture.sv
module pio_capture
    import pio_pkg::*;
#(
    parameter int NUM_IOCLK = 2,
    parameter int SEL_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IOCLK-1:0] io_clk,
    input  logic [SEL_W-1:0]     clk_sel,
    input  logic [MODE_W-1:0]    mode,
    input  logic                 pad_in,
    output logic                 cap_q
);

    logic      line_lvl;
    logic      rise;
    ck_state_e st_q;
    ck_state_e st_d;

    // Pick the I/O clock line; an index past the last line reads as low
    always_comb begin
        if (int'(clk_sel) < NUM_IOCLK) begin
            line_lvl = io_clk[clk_sel];
        end else begin
            line_lvl = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CK_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: T_RISE and T_FALL
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CK_LOW:  if (line_lvl)  st_d = CK_HIGH;
            CK_HIGH: if (!line_lvl) st_d = CK_LOW;
            default: st_d = CK_LOW;
        endcase
    end

    // Output decode: a rising edge fires only from CK_LOW
    always_comb begin
        rise = 1'b0;
        unique case (st_q)
            CK_LOW:  rise = line_lvl;
            CK_HIGH: rise = 1'b0;
            default: rise = 1'b0;
        endcase
    end

    // Shared register/latch storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
        end else if (mode == PM_REG_IN && rise) begin
            cap_q <= pad_in;
        end else if (mode == PM_LAT_IN && line_lvl) begin
            cap_q <= pad_in;
        end
    end

    // R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_REG_IN && !rise) |=> $stable(cap_q));

    // R2
    reg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_REG_IN && rise) |=> (cap_q == $past(pad_in)));

    // R3
    lat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_LAT_IN && line_lvl) |=> (cap_q == $past(pad_in)));

    // R3
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_LAT_IN && !line_lvl) |=> $stable(cap_q));

    // R10
    always @(posedge clk) begin
        if (!rst_n) begin
            rst_clear_chk: assert (cap_q == 1'b0 && st_q == CK_LOW);
        end
    end

endmodule

// File: rtl/pio_oe_ctl.sv
module pio_oe_ctl
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              oe_sel,
    input  logic              glb_oe,
    input  logic              pt_oe,
    input  logic              drv_data,
    output logic              pad_oe,
    output logic              pad_out
);

    logic may_drive;
    logic sel_en;

    // Only the output and bidirectional roles may drive
    always_comb begin
        case (mode)
            PM_OUT, PM_BIDIR: may_drive = 1'b1;
            default:          may_drive = 1'b0;
        endcase
    end

    // Enable source selection
    always_comb begin
        sel_en  = oe_sel ? glb_oe : pt_oe;
        pad_oe  = may_drive & sel_en;
        pad_out = pad_oe & drv_data;
    end

    // R8
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe |-> !pad_out);

    // R6
    no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> (mode == PM_OUT || mode == PM_BIDIR));

endmodule

// File: rtl/pio_cell.sv
module pio_cell
    import pio_pkg::*;
#(
    parameter int NUM_IOCLK = 2,
    parameter int SEL_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IOCLK-1:0] io_clk,
    input  logic                 glb_oe,
    input  logic [MODE_W-1:0]    cfg_mode,
    input  logic [SEL_W-1:0]     cfg_clk_sel,
    input  logic                 cfg_oe_sel,
    input  logic                 pt_oe,
    input  logic                 drv_data,
    output logic                 rcv_data,
    input  logic                 pad_in,
    output logic                 pad_out,
    output logic                 pad_oe
);

    logic cap_q;

    pio_capture #(
        .NUM_IOCLK (NUM_IOCLK),
        .SEL_W     (SEL_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_clk  (io_clk),
        .clk_sel (cfg_clk_sel),
        .mode    (cfg_mode),
        .pad_in  (pad_in),
        .cap_q   (cap_q)
    );

    pio_oe_ctl u_oe (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_mode),
        .oe_sel   (cfg_oe_sel),
        .glb_oe   (glb_oe),
        .pt_oe    (pt_oe),
        .drv_data (drv_data),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out)
    );

    // Receive path selection by role
    always_comb begin
        case (cfg_mode)
            PM_COMB_IN, PM_BIDIR: rcv_data = pad_in;
            PM_REG_IN, PM_LAT_IN: rcv_data = cap_q;
            default:              rcv_data = 1'b0;
        endcase
    end

    // R4
    out_rcv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == PM_OUT) |-> !rcv_data);

    // R6
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode > PM_BIDIR) |-> (!rcv_data && !pad_oe));

endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int NCELL     = 4,
    parameter int NUM_IOCLK = 2,
    parameter int SEL_W     = (NUM_IOCLK > 1) ? $clog2(NUM_IOCLK) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_IOCLK-1:0]   io_clk,
    input  logic                   glb_oe,
    input  logic [NCELL*MODE_W-1:0] cfg_mode,
    input  logic [NCELL*SEL_W-1:0] cfg_clk_sel,
    input  logic [NCELL-1:0]       cfg_oe_sel,
    input  logic [NCELL-1:0]       pt_oe,
    input  logic [NCELL-1:0]       drv_data,
    output logic [NCELL-1:0]       rcv_data,
    input  logic [NCELL-1:0]       pad_in,
    output logic [NCELL-1:0]       pad_out,
    output logic [NCELL-1:0]       pad_oe
);

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        pio_cell #(
            .NUM_IOCLK (NUM_IOCLK),
            .SEL_W     (SEL_W)
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .io_clk      (io_clk),
            .glb_oe      (glb_oe),
            .cfg_mode    (cfg_mode[i*MODE_W +: MODE_W]),
            .cfg_clk_sel (cfg_clk_sel[i*SEL_W +: SEL_W]),
            .cfg_oe_sel  (cfg_oe_sel[i]),
            .pt_oe       (pt_oe[i]),
            .drv_data    (drv_data[i]),
            .rcv_data    (rcv_data[i]),
            .pad_in      (pad_in[i]),
            .pad_out     (pad_out[i]),
            .pad_oe      (pad_oe[i])
        );
    end

endmodule

// File: tb/pio_bank_tb.sv
module pio_bank_tb;

    localparam int NCELL = 4;
    localparam int NIOCK = 2;
    localparam int SELW  = 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NIOCK-1:0] io_clk;
    logic             glb_oe;
    logic [NCELL*3-1:0] cfg_mode;
    logic [NCELL*SELW-1:0] cfg_clk_sel;
    logic [NCELL-1:0] cfg_oe_sel, pt_oe, drv_data, rcv_data, pad_in, pad_out, pad_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    pio_bank #(.NCELL(NCELL), .NUM_IOCLK(NIOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_clk(io_clk), .glb_oe(glb_oe),
        .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel), .cfg_oe_sel(cfg_oe_sel),
        .pt_oe(pt_oe), .drv_data(drv_data), .rcv_data(rcv_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] pat(input int k);
        case (k)
            0: pat = 4'h0;
            1: pat = 4'hF;
            2: pat = 4'hA;
            default: pat = 4'h5;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        io_clk = '0;
        glb_oe = 1'b0;
        cfg_mode = {NCELL{3'd1}};
        cfg_clk_sel = '0;
        cfg_oe_sel = '0;
        pt_oe = '0;
        drv_data = '0;
        pad_in = 4'hF;
        tick(); tick();
        // R10: reset holds storage at zero
        check("R10 reset state rcv", rcv_data, 4'h0);
        check("R10 reset state oe", pad_oe, 4'h0);
        rst_n = 1'b1;
        tick();

        // Combinational sweep over all role codes and enable sources
        for (int m = 0; m < 8; m++) begin
            for (int os = 0; os < 2; os++) begin
                for (int g = 0; g < 2; g++) begin
                    for (int pt = 0; pt < 16; pt++) begin
                        for (int dk = 0; dk < 4; dk++) begin
                            for (int pk = 0; pk < 4; pk++) begin
                                logic [3:0] e_oe, e_out, e_rcv, sel;
                                logic drives;
                                string tag;
                                cfg_mode   = {NCELL{3'(m)}};
                                cfg_oe_sel = os[0] ? 4'hF : 4'h0;
                                glb_oe     = g[0];
                                pt_oe      = 4'(pt);
                                drv_data   = pat(dk);
                                pad_in     = pat(pk);
                                #1;
                                drives = (m == 3) || (m == 4);
                                sel    = os[0] ? {4{g[0]}} : 4'(pt);
                                e_oe   = drives ? sel : 4'h0;
                                e_out  = e_oe & pat(dk);
                                e_rcv  = (m == 0 || m == 4) ? pat(pk) : 4'h0;
                                tag = (m == 0) ? "R1" : (m == 3) ? "R4" :
                                      (m == 4) ? "R5" : (m > 4) ? "R6" : "R2";
                                check({tag, " R7 pad_oe"}, pad_oe, e_oe);
                                check({tag, " R8 pad_out"}, pad_out, e_out);
                                if (m != 1 && m != 2) check({tag, " rcv_data"}, rcv_data, e_rcv);
                            end
                        end
                    end
                end
            end
        end

        // Mixed roles across cells: in, out, bidir, bad code
        cfg_mode = {3'd7, 3'd4, 3'd3, 3'd0};
        cfg_oe_sel = 4'b0110;
        glb_oe = 1'b1;
        pt_oe = 4'b1010;
        drv_data = 4'hF;
        pad_in = 4'hF;
        #1;
        check("R7 mixed pad_oe", pad_oe, 4'b0110);
        check("R5 mixed rcv", rcv_data, 4'b0101);

        // Registered capture on line 0
        cfg_mode = {NCELL{3'd1}};
        cfg_clk_sel = '0;
        io_clk = 2'b00;
        tick();
        pad_in = 4'hA; io_clk = 2'b01;
        tick();
        check("R2 capture on rise", rcv_data, 4'hA);
        pad_in = 4'h5;
        tick();
        check("R2 hold while high", rcv_data, 4'hA);
        io_clk = 2'b00;
        tick();
        check("R2 hold after fall", rcv_data, 4'hA);
        pad_in = 4'h3; io_clk = 2'b10;
        tick(); tick();
        check("R9 other line ignored", rcv_data, 4'hA);
        io_clk = 2'b11;
        tick();
        check("R2 capture second rise", rcv_data, 4'h3);

        // Line 1 selected
        cfg_clk_sel = '1;
        io_clk = 2'b00;
        tick();
        pad_in = 4'hC; io_clk = 2'b01;
        tick();
        check("R9 line 0 ignored when line 1 chosen", rcv_data, 4'h3);
        io_clk = 2'b10;
        tick();
        check("R9 line 1 capture", rcv_data, 4'hC);

        // Role switched in while line already high: no capture
        cfg_mode = {NCELL{3'd0}};
        tick();
        pad_in = 4'h6;
        cfg_mode = {NCELL{3'd1}};
        tick();
        check("R2 no capture without low-to-high", rcv_data, 4'hC);

        // Latched capture on line 0
        cfg_mode = {NCELL{3'd2}};
        cfg_clk_sel = '0;
        io_clk = 2'b01;
        pad_in = 4'h6;
        tick();
        check("R3 latch open", rcv_data, 4'h6);
        pad_in = 4'h9;
        tick();
        check("R3 latch follows", rcv_data, 4'h9);
        io_clk = 2'b00;
        pad_in = 4'hE;
        tick(); tick();
        check("R3 latch holds while low", rcv_data, 4'h9);
        io_clk = 2'b10;
        tick();
        check("R9 latch ignores other line", rcv_data, 4'h9);

        // Asynchronous clear between edges
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        check("R10 async clear", rcv_data, 4'h0);
        tick();
        rst_n = 1'b1;
        io_clk = 2'b01;
        pad_in = 4'h7;
        tick();
        check("R3 latch after reset", rcv_data, 4'h7);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule